// File: doc/BRIEF.md
# Edge-Triggered Phase-Frequency Comparator

This block compares the timing of two pulse trains on a fast system clock. The reference input carries the conditioned ignition pulse train. The feedback input carries the oscillator output after the selectable divider. Only rising edges count, so the duty cycle of either input has no effect on the result.

A reference edge arms a pump-up state and a feedback edge arms a pump-down state. When both are armed, both clear on the following clock. This drives the loop toward zero phase offset between the two edge trains. The block presents the result in three forms:
- a pair of pump outputs, where both low means the idle or high-impedance condition;
- a two-bit signed error for a digital loop filter;
- a lock indication that drops once one side has stayed armed for too long.

Top module: `edge_phase_comparator`

## Requirements
- R1: While reset is asserted and directly after it, pumpUp and pumpDn are 0, phaseErr is 2'b00 and lockOk is 1.
- R2: A rising edge on refIn sets the up state. With the default two synchronizer stages, the up state is visible at the outputs after the third rising clock edge that follows the input change.
- R3: A rising edge on fbIn sets the down state, with the same three-clock latency as R2.
- R4: When the up and down states are both set, both are clear one clock later, unless a new edge arrives in that clock. Both pumps are low while both states are set and after they clear.
- R5: phaseErr is 2'b01 (+1) when only the up state is set, 2'b11 (-1) when only the down state is set, and 2'b00 otherwise. pumpUp and pumpDn are never high together.
- R6: Falling edges and steady levels on either input have no effect on the outputs. A reference input with 25% or 75% duty cycle against a feedback input with 50% duty cycle, with aligned rising edges, gives the same result.
- R7: Rising edges on both inputs in the same clock leave phaseErr at 0 and lockOk at 1 throughout.
- R8: lockOk is 0 exactly in those clocks where a single-sided state (up only or down only) has already lasted LOCK_LIMIT (default 4) full clocks without a break. It is 1 at all other times.
- R9: When the reference edges come more often than the feedback edges, phaseErr is never -1 and reaches +1. In the opposite case it is never +1 and reaches -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples both inputs |
| rstN | input | 1 | Asynchronous reset, active low |
| refIn | input | 1 | Reference pulse train (asynchronous) |
| fbIn | input | 1 | Divided oscillator feedback (asynchronous) |
| pumpUp | output | 1 | Pump-up request, high while only the up state is set |
| pumpDn | output | 1 | Pump-down request, high while only the down state is set |
| phaseErr | output | 2 | Signed phase error: +1, -1 or 0 |
| lockOk | output | 1 | Lock indication, low after a long single-sided run |

## Verification
The assertions assume that both inputs are low when reset is released, because a high level would look like a rising edge. They also assume that each input pulse is held for at least one full clock, so that every level change reaches the edge detectors. The bench drives the inputs on falling clock edges and keeps every high and low phase several clocks long. It applies reset between scenarios so that a state left armed by one pattern does not carry into the next. Frequency-mismatch patterns use periods far longer than the synchronizer depth.

// File: rtl/edge_pd_pkg.sv
package edge_pd_pkg;

  // Rising-edge strobes from the datapath to the control
  typedef struct packed {
    logic refRise;
    logic fbRise;
  } pd_edges_t;

  // Armed pump states from the control back to the datapath
  typedef struct packed {
    logic upSet;
    logic dnSet;
  } pd_state_t;

endpackage

// File: rtl/pd_control.sv
module pd_control
  import edge_pd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  pd_edges_t edges,
  output pd_state_t state
);

  logic upQ, dnQ;
  logic bothSet;

  assign bothSet = upQ & dnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ <= 1'b0;
      dnQ <= 1'b0;
    end else if (bothSet) begin
      // Both armed: drop them, but keep any edge arriving right now
      upQ <= edges.refRise;
      dnQ <= edges.fbRise;
    end else begin
      upQ <= upQ | edges.refRise;
      dnQ <= dnQ | edges.fbRise;
    end
  end

  assign state.upSet = upQ;
  assign state.dnSet = dnQ;

endmodule

// File: rtl/pd_datapath.sv
module pd_datapath
  import edge_pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_LIMIT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refIn,
  input  logic              fbIn,
  input  pd_state_t         state,
  output pd_edges_t         edges,
  output logic              pumpUp,
  output logic              pumpDn,
  output logic signed [1:0] phaseErr,
  output logic              lockOk
);

  localparam int CNT_W = $clog2(LOCK_LIMIT + 1);
  localparam logic [CNT_W-1:0] LOCK_CAP = CNT_W'(LOCK_LIMIT);

  logic [1:0] rawIn;
  logic [1:0] riseVec;

  assign rawIn = {fbIn, refIn};

  // One synchronizer plus edge detector per input channel
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [SYNC_STAGES:0] pipeQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipeQ <= '0;
      else       pipeQ <= {pipeQ[SYNC_STAGES-1:0], rawIn[ch]};
    end
    assign riseVec[ch] = pipeQ[SYNC_STAGES-1] & ~pipeQ[SYNC_STAGES];
  end

  assign edges.refRise = riseVec[0];
  assign edges.fbRise  = riseVec[1];

  // Pump outputs and signed error
  logic upOnly, dnOnly, singleSide;

  assign upOnly     = state.upSet & ~state.dnSet;
  assign dnOnly     = state.dnSet & ~state.upSet;
  assign singleSide = upOnly | dnOnly;

  assign pumpUp = upOnly;
  assign pumpDn = dnOnly;

  always_comb begin
    if (upOnly)      phaseErr = 2'sb01;
    else if (dnOnly) phaseErr = 2'sb11;
    else             phaseErr = 2'sb00;
  end

  // Run-length timer for the lock indication, saturating at the limit
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   runCnt <= '0;
    else if (!singleSide)        runCnt <= '0;
    else if (runCnt != LOCK_CAP) runCnt <= runCnt + 1'b1;
  end

  assign lockOk = !(singleSide && (runCnt >= LOCK_CAP));

endmodule

// File: rtl/edge_phase_comparator.sv
module edge_phase_comparator
  import edge_pd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_LIMIT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refIn,
  input  logic              fbIn,
  output logic              pumpUp,
  output logic              pumpDn,
  output logic signed [1:0] phaseErr,
  output logic              lockOk
);

  pd_edges_t edges;
  pd_state_t state;

  pd_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .LOCK_LIMIT (LOCK_LIMIT)
  ) datapath_i (
    .clk     (clk),
    .rstN    (rstN),
    .refIn   (refIn),
    .fbIn    (fbIn),
    .state   (state),
    .edges   (edges),
    .pumpUp  (pumpUp),
    .pumpDn  (pumpDn),
    .phaseErr(phaseErr),
    .lockOk  (lockOk)
  );

  pd_control control_i (
    .clk  (clk),
    .rstN (rstN),
    .edges(edges),
    .state(state)
  );

endmodule

// File: rtl/pd_checker.sv
module pd_checker (
  input logic       clk,
  input logic       rstN,
  input logic       refRise,
  input logic       fbRise,
  input logic       upSet,
  input logic       dnSet,
  input logic       pumpUp,
  input logic       pumpDn,
  input logic [1:0] phaseErr,
  input logic       lockOk
);

  assert_up_after_ref_R2: assert property (@(posedge clk) disable iff (!rstN)
    refRise |=> upSet);

  assert_dn_after_fb_R3: assert property (@(posedge clk) disable iff (!rstN)
    fbRise |=> dnSet);

  assert_clear_after_both_R4: assert property (@(posedge clk) disable iff (!rstN)
    (upSet && dnSet && !refRise && !fbRise) |=> (!upSet && !dnSet));

  assert_pump_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pumpUp, pumpDn}));

  assert_err_up_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phaseErr == 2'b01) |-> (pumpUp && !pumpDn));

  assert_err_dn_R5: assert property (@(posedge clk) disable iff (!rstN)
    (phaseErr == 2'b11) |-> (pumpDn && !pumpUp));

  assert_lock_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!pumpUp && !pumpDn) |-> lockOk);

  assert_unlock_needs_run_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!lockOk && rstN) |-> $stable({pumpUp, pumpDn}));

endmodule

bind edge_phase_comparator pd_checker chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .refRise (edges.refRise),
  .fbRise  (edges.fbRise),
  .upSet   (state.upSet),
  .dnSet   (state.dnSet),
  .pumpUp  (pumpUp),
  .pumpDn  (pumpDn),
  .phaseErr(phaseErr),
  .lockOk  (lockOk)
);

// File: tb/edge_phase_comparator_tb_top.sv
module edge_phase_comparator_tb_top;

  logic clk = 1'b0;
  logic rstN;
  logic refIn, fbIn;
  logic pumpUp, pumpDn, lockOk;
  logic signed [1:0] phaseErr;

  int checkCount = 0;
  int failCount  = 0;

  localparam logic [1:0] ERR_POS  = 2'b01;
  localparam logic [1:0] ERR_NEG  = 2'b11;
  localparam logic [1:0] ERR_ZERO = 2'b00;

  always #10 clk = ~clk;

  edge_phase_comparator dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .refIn   (refIn),
    .fbIn    (fbIn),
    .pumpUp  (pumpUp),
    .pumpDn  (pumpDn),
    .phaseErr(phaseErr),
    .lockOk  (lockOk)
  );

  task automatic checkVal(input string req, input string what,
                          input logic [3:0] act, input logic [3:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN  = 1'b0;
    refIn = 1'b0;
    fbIn  = 1'b0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN  = 1'b0;
    refIn = 1'b0;
    fbIn  = 1'b0;
    step(1);
    checkVal("R1", "pumps in reset", {2'b00, pumpUp, pumpDn}, 4'h0);
    checkVal("R1", "err in reset", {2'b00, phaseErr}, {2'b00, ERR_ZERO});
    checkVal("R1", "lock in reset", {3'b000, lockOk}, 4'h1);
    rstN = 1'b1;
    step(2);
    checkVal("R1", "err after reset", {2'b00, phaseErr}, {2'b00, ERR_ZERO});
    checkVal("R1", "lock after reset", {3'b000, lockOk}, 4'h1);
  endtask

  // Reference leads feedback by five clocks: long enough to drop lock
  task automatic testLeading();
    applyReset();
    refIn = 1'b1;
    step(3);
    checkVal("R2", "err after ref edge", {2'b00, phaseErr}, {2'b00, ERR_POS});
    checkVal("R2", "pumpUp after ref edge", {3'b000, pumpUp}, 4'h1);
    checkVal("R8", "lock at run start", {3'b000, lockOk}, 4'h1);
    step(2);
    checkVal("R8", "lock at third clock of run", {3'b000, lockOk}, 4'h1);
    fbIn = 1'b1;
    step(2);
    checkVal("R5", "err held while leading", {2'b00, phaseErr}, {2'b00, ERR_POS});
    checkVal("R8", "lock dropped after limit", {3'b000, lockOk}, 4'h0);
    step(1);
    checkVal("R4", "err when both set", {2'b00, phaseErr}, {2'b00, ERR_ZERO});
    checkVal("R4", "pumps when both set", {2'b00, pumpUp, pumpDn}, 4'h0);
    checkVal("R8", "lock back when both set", {3'b000, lockOk}, 4'h1);
    step(1);
    checkVal("R4", "pumps after clear", {2'b00, pumpUp, pumpDn}, 4'h0);
    refIn = 1'b0;
    fbIn  = 1'b0;
    step(4);
    checkVal("R6", "falling edges ignored", {2'b00, phaseErr}, {2'b00, ERR_ZERO});
  endtask

  // Feedback leads reference by three clocks: stays within lock limit
  task automatic testLagging();
    applyReset();
    fbIn = 1'b1;
    step(3);
    checkVal("R3", "err after fb edge", {2'b00, phaseErr}, {2'b00, ERR_NEG});
    checkVal("R3", "pumpDn after fb edge", {3'b000, pumpDn}, 4'h1);
    refIn = 1'b1;
    step(2);
    checkVal("R5", "err held while lagging", {2'b00, phaseErr}, {2'b00, ERR_NEG});
    checkVal("R8", "lock kept in short run", {3'b000, lockOk}, 4'h1);
    step(1);
    checkVal("R4", "err when both set (lag)", {2'b00, phaseErr}, {2'b00, ERR_ZERO});
    step(1);
    checkVal("R4", "pumps after clear (lag)", {2'b00, pumpUp, pumpDn}, 4'h0);
  endtask

  // Aligned rising edges, reference duty given in clocks of a 16-clock period
  task automatic testAligned(input int refHigh);
    applyReset();
    for (int c = 0; c < 64; c++) begin
      refIn = ((c % 16) < refHigh);
      fbIn  = ((c % 16) < 8);
      step(1);
      checkVal("R7", "err with coincident edges", {2'b00, phaseErr}, {2'b00, ERR_ZERO});
      checkVal("R6", "lock independent of duty", {3'b000, lockOk}, 4'h1);
    end
  endtask

  // Unequal periods; refFaster selects which input runs faster
  task automatic testMismatch(input bit refFaster);
    int  refPer, fbPer;
    bit  sawPos, sawNeg;
    applyReset();
    refPer = refFaster ? 10 : 15;
    fbPer  = refFaster ? 15 : 10;
    sawPos = 1'b0;
    sawNeg = 1'b0;
    for (int c = 0; c < 90; c++) begin
      refIn = ((c % refPer) < (refPer / 2));
      fbIn  = ((c % fbPer) < (fbPer / 2));
      step(1);
      if (phaseErr == ERR_POS) sawPos = 1'b1;
      if (phaseErr == ERR_NEG) sawNeg = 1'b1;
    end
    if (refFaster) begin
      checkVal("R9", "fast ref reaches +1", {3'b000, sawPos}, 4'h1);
      checkVal("R9", "fast ref never -1", {3'b000, sawNeg}, 4'h0);
    end else begin
      checkVal("R9", "fast fb reaches -1", {3'b000, sawNeg}, 4'h1);
      checkVal("R9", "fast fb never +1", {3'b000, sawPos}, 4'h0);
    end
  endtask

  initial begin
    #(20 * 200000);
    failCount++;
    checkCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    rstN  = 1'b0;
    refIn = 1'b0;
    fbIn  = 1'b0;
    testReset();
    testLeading();
    testLagging();
    testAligned(4);
    testAligned(12);
    testMismatch(1'b1);
    testMismatch(1'b0);
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule